// File: doc/BRIEF.md
# Triggered Ring Capture and Dump Controller

This block keeps a rolling record of full-rate summed hit-count samples. Every valid sample is written into a circular buffer, so the buffer always holds the most recent samples up to its depth. When a burst trigger is accepted, recording carries on for a programmable number of further samples and then stops. That keeps a window of data around the trigger moment, with history before it and a tail after it.

A trigger can come from two places. The internal one fires when a windowed hit sum, supplied alongside a valid strobe, reaches a programmable threshold. The external one is a single input driven by another system. A two-bit select picks internal only, external only, or either source. Once the buffer is frozen, its contents leave on a dedicated valid/ready stream in the order they were recorded, starting from the oldest retained sample. After the final beat the buffer is emptied and recording resumes.

In a full system the store would be a large external memory. Here it is an on-chip array whose depth is a parameter, so that it can be scaled down for test.

Top module: `capbuf_ctrl`

## Requirements
- R1: After reset, `armed` is 1, and `capturing`, `dumping`, `missed_trig` and `dmp_valid` are all 0.
- R2: While armed or capturing, every cycle with `smp_valid` high writes `smp_data` into the ring. Once more than DEPTH samples have been written, the ring keeps only the newest DEPTH.
- R3: The internal trigger fires only in a cycle where `win_valid` is 1 and `win_sum` is greater than or equal to `thresh`. A sum one below the threshold, or any sum without `win_valid`, does not fire it.
- R4: `src_sel` encoding: 0 accepts the internal trigger only, 1 accepts `ext_trig` only, 2 and 3 accept either. A trigger from an unselected source leaves the block armed.
- R5: An accepted trigger starts capture. The sample in the trigger cycle counts as pre-trigger. Exactly `post_len` further valid samples are written, and then the ring freezes and `dumping` rises. With `post_len` = 0 the ring freezes at once.
- R6: A dump presents exactly min(samples written since arming, DEPTH) beats. It starts at the oldest retained sample and goes on in recording order, wrapping at the end of the ring.
- R7: While `dmp_valid` is 1 and `dmp_ready` is 0, `dmp_data` and `dmp_valid` hold steady. `dmp_last` is 1 only on the final beat.
- R8: A trigger that arrives while capturing or dumping is ignored and sets `missed_trig`. That flag stays at 1 until reset.
- R9: Samples presented while the ring is frozen or being dumped are discarded. They never appear in any later dump.
- R10: After the last beat is accepted, the block empties the ring and returns to armed. If a freeze finds the ring empty, the block re-arms without presenting any beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Full-rate sample strobe |
| smp_data | input | DW | Summed hit count sample |
| win_valid | input | 1 | Windowed sum strobe |
| win_sum | input | SW | Windowed hit sum for the internal trigger |
| thresh | input | SW | Internal trigger threshold |
| ext_trig | input | 1 | External burst trigger |
| src_sel | input | 2 | Trigger source select |
| post_len | input | LW | Post-trigger sample count |
| dmp_ready | input | 1 | Dump stream ready |
| dmp_valid | output | 1 | Dump stream valid |
| dmp_data | output | DW | Dump stream sample |
| dmp_last | output | 1 | Final dump beat |
| armed | output | 1 | Recording, waiting for a trigger |
| capturing | output | 1 | Post-trigger recording |
| dumping | output | 1 | Ring frozen or being read out |
| missed_trig | output | 1 | Sticky flag for an ignored trigger |

## Verification
The hardest situation to set up is a dump that wraps. The oldest retained sample then sits mid-ring while a stalled consumer holds the stream, and a stray trigger lands at the same point. The stimulus writes more than twice the ring depth before firing the external trigger. It pulses the trigger again during post-capture, throttles `dmp_ready` on a fixed pattern, and keeps tagged samples flowing into the frozen ring. The bench's queue model then shows whether any tagged sample leaks into a later dump, and whether the order breaks at the wrap point.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_POST = 2'd1,
    ST_LOAD = 2'd2,
    ST_DUMP = 2'd3
  } cap_state_e;

  localparam logic [1:0] SRC_INT = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
endpackage

// File: rtl/capbuf_trig.sv
module capbuf_trig
  import capbuf_pkg::*;
#(
  parameter int SW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_sel,
  input  logic          win_valid,
  input  logic [SW-1:0] win_sum,
  input  logic [SW-1:0] thresh,
  input  logic          ext_trig,
  output logic          trig_int,
  output logic          trig_ext,
  output logic          trig_hit
);
  function automatic logic sum_fires(input logic v, input logic [SW-1:0] s, input logic [SW-1:0] t);
    return v && (s >= t);
  endfunction

  logic int_en, ext_en;
  assign int_en   = (src_sel != SRC_EXT);
  assign ext_en   = (src_sel != SRC_INT);
  assign trig_int = int_en && sum_fires(win_valid, win_sum, thresh);
  assign trig_ext = ext_en && ext_trig;
  assign trig_hit = trig_int || trig_ext;

  AST_TRIG_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> (ext_trig || win_valid)); // R3
  AST_INT_ONLY_MASKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_INT && !win_valid) |-> !trig_hit); // R4
endmodule

// File: rtl/capbuf_ring.sv
module capbuf_ring #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  input  logic [PW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] wptr,
  output logic [CW-1:0] fill
);
  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] fill_next(input logic [CW-1:0] f);
    return (f == CW'(DEPTH)) ? f : f + 1'b1;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (clear) begin
      wptr <= '0;
      fill <= '0;
    end else if (wr_en) begin
      wptr <= ptr_next(wptr);
      fill <= fill_next(fill);
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R2
  AST_WPTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && wptr == PW'(DEPTH - 1)) |=> (wptr == '0)); // R2
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_hit,
  input  logic          smp_valid,
  input  logic [LW-1:0] post_len,
  input  logic [CW-1:0] fill,
  input  logic [PW-1:0] wptr,
  input  logic          dmp_ready,
  output logic          wr_en,
  output logic          ring_clear,
  output logic [PW-1:0] rd_ptr,
  output cap_state_e    state,
  output logic          missed,
  output logic          dmp_valid,
  output logic          dmp_last
);
  function automatic logic [PW-1:0] oldest(input logic [PW-1:0] wp, input logic [CW-1:0] f);
    return (f == CW'(DEPTH)) ? wp : '0;
  endfunction

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [LW-1:0] post_cnt;
  logic [CW-1:0] left;

  logic ev_trig_accept, ev_trig_miss, ev_post_done, ev_beat, ev_last, ev_empty;
  assign ev_trig_accept = (state == ST_ARM) && trig_hit;
  assign ev_trig_miss   = (state != ST_ARM) && trig_hit;
  assign ev_post_done   = (state == ST_POST) && smp_valid && (post_cnt == LW'(1));
  assign ev_beat        = (state == ST_DUMP) && dmp_ready;
  assign ev_last        = ev_beat && (left == CW'(1));
  assign ev_empty       = (state == ST_LOAD) && (fill == '0);

  assign wr_en      = smp_valid && (state == ST_ARM || state == ST_POST);
  assign ring_clear = ev_last || ev_empty;
  assign dmp_valid  = (state == ST_DUMP);
  assign dmp_last   = dmp_valid && (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ARM;
      post_cnt <= '0;
      left     <= '0;
      rd_ptr   <= '0;
    end else begin
      case (state)
        ST_ARM: begin
          if (ev_trig_accept) begin
            post_cnt <= post_len;
            state    <= (post_len == '0) ? ST_LOAD : ST_POST;
          end
        end
        ST_POST: begin
          if (ev_post_done) state <= ST_LOAD;
          else if (smp_valid) post_cnt <= post_cnt - 1'b1;
        end
        ST_LOAD: begin
          rd_ptr <= oldest(wptr, fill);
          left   <= fill;
          state  <= (fill == '0) ? ST_ARM : ST_DUMP;
        end
        ST_DUMP: begin
          if (ev_beat) begin
            rd_ptr <= ptr_next(rd_ptr);
            left   <= left - 1'b1;
            if (ev_last) state <= ST_ARM;
          end
        end
        default: state <= ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            missed <= 1'b0;
    else if (ev_trig_miss) missed <= 1'b1;
  end

  AST_POST_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_post_done |=> (state == ST_LOAD)); // R5
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> missed); // R8
  AST_MISS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trig_miss |=> missed); // R8
  AST_LAST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> (state == ST_ARM)); // R10
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMP) |-> (left != '0 && left <= CW'(DEPTH))); // R6
  AST_STALL_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dmp_valid && !dmp_ready) |=> (dmp_valid && $stable(rd_ptr))); // R7
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SW    = 20,
  parameter int DEPTH = 16,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          win_valid,
  input  logic [SW-1:0] win_sum,
  input  logic [SW-1:0] thresh,
  input  logic          ext_trig,
  input  logic [1:0]    src_sel,
  input  logic [LW-1:0] post_len,
  input  logic          dmp_ready,
  output logic          dmp_valid,
  output logic [DW-1:0] dmp_data,
  output logic          dmp_last,
  output logic          armed,
  output logic          capturing,
  output logic          dumping,
  output logic          missed_trig
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          trig_int, trig_ext, trig_hit;
  logic          wr_en, ring_clear;
  logic [PW-1:0] rd_ptr, wptr;
  logic [CW-1:0] fill;
  cap_state_e    state;

  capbuf_trig #(.SW(SW)) u_trig (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .win_valid(win_valid),
    .win_sum(win_sum), .thresh(thresh), .ext_trig(ext_trig),
    .trig_int(trig_int), .trig_ext(trig_ext), .trig_hit(trig_hit)
  );

  capbuf_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(smp_data),
    .clear(ring_clear), .rd_ptr(rd_ptr), .rd_data(dmp_data),
    .wptr(wptr), .fill(fill)
  );

  capbuf_seq #(.DEPTH(DEPTH), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_hit(trig_hit), .smp_valid(smp_valid),
    .post_len(post_len), .fill(fill), .wptr(wptr), .dmp_ready(dmp_ready),
    .wr_en(wr_en), .ring_clear(ring_clear), .rd_ptr(rd_ptr), .state(state),
    .missed(missed_trig), .dmp_valid(dmp_valid), .dmp_last(dmp_last)
  );

  assign armed     = (state == ST_ARM);
  assign capturing = (state == ST_POST);
  assign dumping   = (state == ST_LOAD) || (state == ST_DUMP);

  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dumping |-> !wr_en); // R9
  AST_DUMP_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dmp_valid && !dmp_ready) |=> (dmp_valid && $stable(dmp_data))); // R7
  AST_ACCEPT_LEAVES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trig_hit) |=> !armed); // R5
  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({armed, capturing, dumping})); // R10
endmodule

// File: tb/capbuf_ctrl_tb_top.sv
module capbuf_ctrl_tb_top;
  localparam int DW = 16, SW = 20, DEPTH = 16, LW = 16;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, win_valid = 0, ext_trig = 0, dmp_ready = 0;
  logic [DW-1:0] smp_data = '0;
  logic [SW-1:0] win_sum = '0, thresh = 20'd100;
  logic [1:0] src_sel = 2'd0;
  logic [LW-1:0] post_len = '0;
  logic dmp_valid, dmp_last, armed, capturing, dumping, missed_trig;
  logic [DW-1:0] dmp_data;

  capbuf_ctrl #(.DW(DW), .SW(SW), .DEPTH(DEPTH), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .win_valid(win_valid), .win_sum(win_sum), .thresh(thresh), .ext_trig(ext_trig),
    .src_sel(src_sel), .post_len(post_len), .dmp_ready(dmp_ready),
    .dmp_valid(dmp_valid), .dmp_data(dmp_data), .dmp_last(dmp_last), .armed(armed),
    .capturing(capturing), .dumping(dumping), .missed_trig(missed_trig)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 arm, 1 post, 2 load, 3 dump
  int m_mode = 0, m_cnt = 0;
  bit m_missed = 0;
  int q[$], dq[$];

  always @(posedge clk) begin
    bit trig;
    if (!rst_n) begin
      m_mode = 0; m_missed = 0; q.delete(); dq.delete();
    end else begin
      trig = (src_sel != 2'd1 && win_valid && win_sum >= thresh) ||
             (src_sel != 2'd0 && ext_trig);
      case (m_mode)
        0: begin
          if (smp_valid) begin q.push_back(smp_data); if (q.size() > DEPTH) void'(q.pop_front()); end
          if (trig) begin
            if (post_len == 0) m_mode = 2; else begin m_cnt = post_len; m_mode = 1; end
          end
        end
        1: begin
          if (trig) m_missed = 1;
          if (smp_valid) begin
            q.push_back(smp_data); if (q.size() > DEPTH) void'(q.pop_front());
            if (m_cnt == 1) m_mode = 2; else m_cnt--;
          end
        end
        2: begin
          if (trig) m_missed = 1;
          dq = q; q.delete();
          m_mode = (dq.size() != 0) ? 3 : 0;
        end
        default: begin
          if (trig) m_missed = 1;
          if (dmp_ready) begin void'(dq.pop_front()); if (dq.size() == 0) m_mode = 0; end
        end
      endcase
    end
    #2;
    if (rst_n && !done) begin
      check(armed == (m_mode == 0), "R10 armed", armed, m_mode == 0);
      check(capturing == (m_mode == 1), "R5 capturing", capturing, m_mode == 1);
      check(dumping == (m_mode >= 2), "R5 dumping", dumping, m_mode >= 2);
      check(missed_trig == m_missed, "R8 missed_trig", missed_trig, m_missed);
      check(dmp_valid == (m_mode == 3), "R6 dmp_valid", dmp_valid, m_mode == 3);
      if (m_mode == 3 && dmp_valid) begin
        check(dmp_data == dq[0], "R6 dmp_data order", dmp_data, dq[0]);
        check(dmp_last == (dq.size() == 1), "R7 dmp_last", dmp_last, dq.size() == 1);
        check(dmp_data[15:12] != 4'hD, "R9 frozen sample leaked", dmp_data, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int sdat = 1;

  task automatic drive(input bit sv, input bit wv, input int ws, input bit ex);
    @(negedge clk);
    smp_valid = sv; win_valid = wv; win_sum = SW'(ws); ext_trig = ex;
    if (sv) begin smp_data = DW'(sdat); sdat++; end
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic run_dump(input int stall_mod, output int beats);
    int k = 0;
    bit held = 0;
    logic [DW-1:0] saved = '0;
    beats = 0;
    while (k < 400) begin
      @(negedge clk);
      if (armed) break;
      dmp_ready = (stall_mod == 0) ? 1'b1 : ((k % stall_mod) != 0);
      smp_valid = 1; smp_data = DW'(16'hD000 | k); win_valid = 0; ext_trig = 0;
      #1;
      if (held) check(dmp_data == saved, "R7 stall hold", dmp_data, saved);
      if (dmp_valid && dmp_ready) beats++;
      held = dmp_valid && !dmp_ready;
      saved = dmp_data;
      k++;
    end
    smp_valid = 0; dmp_ready = 0;
  endtask

  initial begin
    int beats;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    check(armed == 1, "R1 armed", armed, 1);
    check(capturing == 0 && dumping == 0, "R1 busy flags", {capturing, dumping}, 0);
    check(missed_trig == 0, "R1 missed", missed_trig, 0);
    check(dmp_valid == 0, "R1 dmp_valid", dmp_valid, 0);

    // Phase A: internal trigger at threshold, short fill
    src_sel = 2'd0; post_len = 3;
    drive(1, 0, 500, 0); settle();
    check(armed == 1, "R3 sum without win_valid", armed, 1);
    drive(1, 1, 99, 1); settle();
    check(armed == 1, "R3 below threshold / R4 ext masked", armed, 1);
    for (int i = 0; i < 3; i++) drive(1, 1, 50, 0);
    drive(1, 1, 100, 0); settle();
    check(capturing == 1, "R3 fire at threshold", capturing, 1);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(1, 0, 0, 0); settle();
    check(capturing == 1, "R5 still capturing", capturing, 1);
    drive(1, 0, 0, 0); settle();
    check(dumping == 1, "R5 freeze after post_len", dumping, 1);
    run_dump(0, beats);
    check(beats == 9, "R6 beat count short", beats, 9);
    check(armed == 1, "R10 rearm", armed, 1);

    // Phase B: external trigger, wrapped ring, stalls, missed trigger
    src_sel = 2'd1; post_len = 5;
    for (int i = 0; i < 39; i++) drive(1, 1, 900, 0);
    settle();
    check(armed == 1, "R4 internal ignored when external only", armed, 1);
    drive(1, 0, 0, 1);
    drive(1, 0, 0, 1);
    drive(0, 0, 0, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0); settle();
    check(missed_trig == 1, "R8 missed set", missed_trig, 1);
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0);
    run_dump(3, beats);
    check(beats == DEPTH, "R6 beat count wrapped", beats, DEPTH);
    check(armed == 1, "R10 rearm after wrap", armed, 1);

    // Phase C: empty freeze, then either-source internal trigger
    src_sel = 2'd2; post_len = 0;
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 0);
    run_dump(0, beats);
    check(beats == 0, "R10 empty freeze no beats", beats, 0);
    check(armed == 1, "R10 empty rearm", armed, 1);
    post_len = 2;
    drive(1, 0, 0, 0);
    drive(1, 0, 0, 0);
    drive(1, 1, 300, 0);
    drive(1, 0, 0, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    run_dump(2, beats);
    check(beats == 5, "R2 R9 only post-rearm samples", beats, 5);
    check(missed_trig == 1, "R8 sticky", missed_trig, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule